// File: doc/BRIEF.md
# Domain-Based Region Access Checker

This block sits beside a bus fabric and judges every access against a small bank of programmable address windows. Each access brings an address, the ID of the domain that issued it and a direction (read or write). Every window has inclusive lower and upper bounds, a valid flag, and a read-enable and write-enable bit for each implemented domain. The block decides in the same cycle whether the access is allowed or is an access error. Denial is the default. An address that no window covers is refused. Where windows overlap, a single window that refuses the access overrides every window that allows it.

Every refused access produces a one-cycle violation pulse in the next cycle. A system reset controller can use this pulse. The first refused access is also kept in a capture register, which holds the address, domain and direction for later inspection. That register stays frozen until a clear strobe arrives. The windows are loaded through a simple write port that takes a window index, a field select and a data word.

Top module: `region_guard`

## Requirements
- R1: A valid access whose address lies in no valid window gets `acc_err_o`=1 and `acc_allow_o`=0.
- R2: A valid access that hits exactly one window is allowed only if that window's permission bit for the access is 1. Otherwise it is an error.
- R3: When several valid windows hit, the access is allowed only if every one of them grants it. One refusing window makes it an error.
- R4: The permission word encodes domain d's read enable at bit 2d and its write enable at bit 2d+1. The domain ID and `acc_write_i` together pick that bit.
- R5: A domain ID of NUM_DOMAINS or more (4..7 by default) is refused on every access, even inside a window that grants all implemented domains.
- R6: A window hits only if its valid flag is set and start <= address <= end. Both bounds are inclusive.
- R7: The verdict is combinational. While `acc_valid_i`=1, exactly one of `acc_allow_o` and `acc_err_o` is 1. While `acc_valid_i`=0, both are 0.
- R8: `viol_o` is 1 in the cycle after each refused access and 0 in the cycle after any other cycle.
- R9: A refused access that arrives while `cap_valid_o`=0 loads its address, domain ID and write flag and sets `cap_valid_o`. While `cap_valid_o`=1, later errors leave the capture unchanged.
- R10: `cap_clr_i` clears `cap_valid_o`. If an error arrives in the same cycle as the clear, that error is captured.
- R11: A config write sets one field of the indexed window, and an access in the next cycle sees the new value. The field encodings are 0 = start, 1 = end, 2 = permission word (low 2*NUM_DOMAINS bits), 3 = valid (bit 0). After reset all windows are invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Config write strobe |
| cfg_idx_i | input | 3 | Window index to write |
| cfg_field_i | input | 2 | Field select: 0 start, 1 end, 2 perm, 3 valid |
| cfg_data_i | input | 32 | Config write data |
| acc_valid_i | input | 1 | Access present this cycle |
| acc_addr_i | input | 32 | Access address |
| acc_did_i | input | 3 | Requesting domain ID |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_allow_o | output | 1 | Access allowed |
| acc_err_o | output | 1 | Access error |
| viol_o | output | 1 | One-cycle violation pulse, one cycle after an error |
| cap_clr_i | input | 1 | Clears the capture valid flag |
| cap_valid_o | output | 1 | Capture register holds an error |
| cap_addr_o | output | 32 | Captured address |
| cap_did_o | output | 3 | Captured domain ID |
| cap_write_o | output | 1 | Captured direction |

## Verification
The hardest case to reach is a stack of overlapping windows that disagree. Three windows have to be loaded over the same addresses with different permission words, so that one access is granted by two windows and refused by a third. In the same stack, a different access must be granted by all three. The bench builds this stack through the config port, then walks domain and direction combinations across it. It also fires an error in the same cycle as a capture clear, so that the clear and a new capture compete for the register in one cycle.

// File: rtl/region_guard_pkg.sv
package region_guard_pkg;
  typedef enum logic [1:0] {
    FLD_START = 2'd0,
    FLD_END   = 2'd1,
    FLD_PERM  = 2'd2,
    FLD_VALID = 2'd3
  } cfg_field_e;
endpackage

// File: rtl/region_slot.sv
module region_slot import region_guard_pkg::*; #(
  parameter int ADDR_W      = 32,
  parameter int DID_W       = 3,
  parameter int NUM_DOMAINS = 4,
  parameter int IDX_W       = 3,
  parameter int SLOT        = 0,
  localparam int PERM_W     = 2 * NUM_DOMAINS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [IDX_W-1:0]  cfg_idx_i,
  input  logic [1:0]        cfg_field_i,
  input  logic [ADDR_W-1:0] cfg_data_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [DID_W-1:0]  acc_did_i,
  input  logic              acc_write_i,
  output logic              hit_o,
  output logic              deny_o
);
  logic [ADDR_W-1:0] start_q, end_q;
  logic [PERM_W-1:0] perm_q;
  logic              valid_q;
  logic              sel;
  logic              grant;

  assign sel = cfg_we_i && (cfg_idx_i == IDX_W'(SLOT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= '0;
      end_q   <= '0;
      perm_q  <= '0;
      valid_q <= 1'b0;
    end else if (sel) begin
      unique case (cfg_field_e'(cfg_field_i))
        FLD_START: start_q <= cfg_data_i;
        FLD_END:   end_q   <= cfg_data_i;
        FLD_PERM:  perm_q  <= cfg_data_i[PERM_W-1:0];
        FLD_VALID: valid_q <= cfg_data_i[0];
        default:   ;
      endcase
    end
  end

  assign hit_o = valid_q && (acc_addr_i >= start_q) && (acc_addr_i <= end_q);

  // unimplemented domains match no entry and stay ungranted
  always_comb begin
    grant = 1'b0;
    for (int d = 0; d < NUM_DOMAINS; d++) begin
      if (acc_did_i == DID_W'(d))
        grant = acc_write_i ? perm_q[2*d+1] : perm_q[2*d];
    end
  end

  assign deny_o = hit_o && !grant;
endmodule

// File: rtl/region_verdict.sv
module region_verdict #(
  parameter int NUM_REGIONS = 8
) (
  input  logic                   acc_valid_i,
  input  logic [NUM_REGIONS-1:0] hit_i,
  input  logic [NUM_REGIONS-1:0] deny_i,
  output logic                   allow_o,
  output logic                   err_o
);
  logic any_hit, any_deny;
  assign any_hit  = |hit_i;
  assign any_deny = |deny_i;
  // deny wins over allow; a miss is a deny
  assign allow_o = acc_valid_i && any_hit && !any_deny;
  assign err_o   = acc_valid_i && !(any_hit && !any_deny);
endmodule

// File: rtl/region_capture.sv
module region_capture #(
  parameter int ADDR_W = 32,
  parameter int DID_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              err_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DID_W-1:0]  did_i,
  input  logic              write_i,
  input  logic              clr_i,
  output logic              viol_o,
  output logic              cap_valid_o,
  output logic [ADDR_W-1:0] cap_addr_o,
  output logic [DID_W-1:0]  cap_did_o,
  output logic              cap_write_o
);
  logic load;
  assign load = err_i && (clr_i || !cap_valid_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      viol_o      <= 1'b0;
      cap_valid_o <= 1'b0;
      cap_addr_o  <= '0;
      cap_did_o   <= '0;
      cap_write_o <= 1'b0;
    end else begin
      viol_o <= err_i;
      if (load) begin
        cap_valid_o <= 1'b1;
        cap_addr_o  <= addr_i;
        cap_did_o   <= did_i;
        cap_write_o <= write_i;
      end else if (clr_i) begin
        cap_valid_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/region_guard.sv
module region_guard import region_guard_pkg::*; #(
  parameter int NUM_REGIONS = 8,
  parameter int NUM_DOMAINS = 4,
  parameter int ADDR_W      = 32,
  parameter int DID_W       = 3,
  localparam int IDX_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [IDX_W-1:0]  cfg_idx_i,
  input  logic [1:0]        cfg_field_i,
  input  logic [ADDR_W-1:0] cfg_data_i,
  input  logic              acc_valid_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [DID_W-1:0]  acc_did_i,
  input  logic              acc_write_i,
  output logic              acc_allow_o,
  output logic              acc_err_o,
  output logic              viol_o,
  input  logic              cap_clr_i,
  output logic              cap_valid_o,
  output logic [ADDR_W-1:0] cap_addr_o,
  output logic [DID_W-1:0]  cap_did_o,
  output logic              cap_write_o
);
  logic [NUM_REGIONS-1:0] hit_vec;
  logic [NUM_REGIONS-1:0] deny_vec;

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_slot
    region_slot #(
      .ADDR_W(ADDR_W), .DID_W(DID_W), .NUM_DOMAINS(NUM_DOMAINS),
      .IDX_W(IDX_W), .SLOT(r)
    ) u_slot (
      .clk_i, .rst_ni, .cfg_we_i, .cfg_idx_i, .cfg_field_i, .cfg_data_i,
      .acc_addr_i, .acc_did_i, .acc_write_i,
      .hit_o(hit_vec[r]), .deny_o(deny_vec[r])
    );
  end

  region_verdict #(.NUM_REGIONS(NUM_REGIONS)) u_verdict (
    .acc_valid_i, .hit_i(hit_vec), .deny_i(deny_vec),
    .allow_o(acc_allow_o), .err_o(acc_err_o)
  );

  region_capture #(.ADDR_W(ADDR_W), .DID_W(DID_W)) u_capture (
    .clk_i, .rst_ni, .err_i(acc_err_o), .addr_i(acc_addr_i),
    .did_i(acc_did_i), .write_i(acc_write_i), .clr_i(cap_clr_i),
    .viol_o, .cap_valid_o, .cap_addr_o, .cap_did_o, .cap_write_o
  );
endmodule

// File: rtl/region_guard_chk.sv
module region_guard_chk #(
  parameter int NUM_REGIONS = 8,
  parameter int NUM_DOMAINS = 4,
  parameter int ADDR_W      = 32,
  parameter int DID_W       = 3
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   acc_valid_i,
  input logic [ADDR_W-1:0]      acc_addr_i,
  input logic [DID_W-1:0]       acc_did_i,
  input logic                   acc_allow_o,
  input logic                   acc_err_o,
  input logic                   viol_o,
  input logic                   cap_clr_i,
  input logic                   cap_valid_o,
  input logic [ADDR_W-1:0]      cap_addr_o,
  input logic [NUM_REGIONS-1:0] hit_vec,
  input logic [NUM_REGIONS-1:0] deny_vec
);
  // R1
  miss_is_error_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && hit_vec == '0) |-> acc_err_o);
  // R3
  deny_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && deny_vec != '0) |-> (acc_err_o && !acc_allow_o));
  // R5
  bad_domain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && acc_did_i >= DID_W'(NUM_DOMAINS)) |-> acc_err_o);
  // R7
  one_verdict_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i |-> $onehot({acc_allow_o, acc_err_o}));
  // R7
  idle_verdict_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_valid_i |-> !(acc_allow_o || acc_err_o));
  // R8
  viol_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_err_o |=> viol_o);
  // R8
  viol_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_err_o |=> !viol_o);
  // R9
  cap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_valid_o && !cap_clr_i) |=> (cap_valid_o && $stable(cap_addr_o)));
  // R10
  cap_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_clr_i && !acc_err_o) |=> !cap_valid_o);
endmodule

bind region_guard region_guard_chk #(
  .NUM_REGIONS(NUM_REGIONS), .NUM_DOMAINS(NUM_DOMAINS),
  .ADDR_W(ADDR_W), .DID_W(DID_W)
) u_chk (
  .clk_i, .rst_ni, .acc_valid_i, .acc_addr_i, .acc_did_i,
  .acc_allow_o, .acc_err_o, .viol_o, .cap_clr_i, .cap_valid_o,
  .cap_addr_o, .hit_vec, .deny_vec
);

// File: tb/region_guard_test.sv
module region_guard_test;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [2:0]  cfg_idx_i = '0;
  logic [1:0]  cfg_field_i = '0;
  logic [31:0] cfg_data_i = '0;
  logic        acc_valid_i = 1'b0;
  logic [31:0] acc_addr_i = '0;
  logic [2:0]  acc_did_i = '0;
  logic        acc_write_i = 1'b0;
  logic        cap_clr_i = 1'b0;
  logic        acc_allow_o, acc_err_o, viol_o;
  logic        cap_valid_o, cap_write_o;
  logic [31:0] cap_addr_o;
  logic [2:0]  cap_did_o;

  int n_checks = 0;
  int n_fails  = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  region_guard uut (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_idx_i, .cfg_field_i, .cfg_data_i,
    .acc_valid_i, .acc_addr_i, .acc_did_i, .acc_write_i,
    .acc_allow_o, .acc_err_o, .viol_o, .cap_clr_i,
    .cap_valid_o, .cap_addr_o, .cap_did_o, .cap_write_o
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cfg(input int idx, input int fld, input logic [31:0] data);
    @(negedge clk_i);
    acc_valid_i = 1'b0; cap_clr_i = 1'b0;
    cfg_we_i = 1'b1; cfg_idx_i = 3'(idx); cfg_field_i = 2'(fld); cfg_data_i = data;
    @(posedge clk_i); #1;
  endtask

  task automatic window(input int idx, input logic [31:0] lo, input logic [31:0] hi,
                        input logic [31:0] perm);
    cfg(idx, 0, lo); cfg(idx, 1, hi); cfg(idx, 2, perm); cfg(idx, 3, 32'h1);
  endtask

  // drive one access; verdict checked same cycle, viol after the edge
  task automatic access(input string req, input logic [31:0] a, input int d,
                        input logic w, input logic exp_allow, input logic clr = 1'b0);
    @(negedge clk_i);
    cfg_we_i = 1'b0; cap_clr_i = clr;
    acc_valid_i = 1'b1; acc_addr_i = a; acc_did_i = 3'(d); acc_write_i = w;
    #1;
    check({req, " allow"}, 32'(acc_allow_o), 32'(exp_allow));
    check({req, " err"},   32'(acc_err_o),   32'(!exp_allow));
    @(posedge clk_i); #1;
    check("R8 viol", 32'(viol_o), 32'(!exp_allow));
  endtask

  task automatic idle();
    @(negedge clk_i);
    cfg_we_i = 1'b0; acc_valid_i = 1'b0; cap_clr_i = 1'b0;
    #1;
    check("R7 idle allow", 32'(acc_allow_o), 0);
    check("R7 idle err",   32'(acc_err_o),   0);
    @(posedge clk_i); #1;
  endtask

  task automatic test_reset();
    #1;
    check("R7 reset allow", 32'(acc_allow_o), 0);
    check("R7 reset err", 32'(acc_err_o), 0);
    check("R8 reset viol", 32'(viol_o), 0);
    check("R9 reset cap_valid", 32'(cap_valid_o), 0);
    access("R11 all invalid", 32'h0000_1000, 0, 1'b0, 1'b0);
    idle();
    check("R8 viol drops", 32'(viol_o), 0);
  endtask

  task automatic test_single_bounds();
    window(0, 32'h1000, 32'h1FFF, 32'h03);
    access("R6 low edge",  32'h1000, 0, 1'b0, 1'b1);
    access("R6 high edge", 32'h1FFF, 0, 1'b1, 1'b1);
    access("R6 below",     32'h0FFF, 0, 1'b0, 1'b0);
    access("R1 above",     32'h2000, 0, 1'b0, 1'b0);
    access("R2 other domain", 32'h1400, 1, 1'b0, 1'b0);
    idle();
  endtask

  task automatic test_direction();
    window(5, 32'h6_0000, 32'h6_FFFF, 32'h04);  // domain 1 read only
    access("R4 dom1 read",  32'h6_0100, 1, 1'b0, 1'b1);
    access("R4 dom1 write", 32'h6_0100, 1, 1'b1, 1'b0);
    access("R2 dom0 read",  32'h6_0100, 0, 1'b0, 1'b0);
    idle();
  endtask

  task automatic test_overlap();
    window(1, 32'h1800, 32'h18FF, 32'hFE);  // refuses domain 0 read
    window(2, 32'h1800, 32'h18FF, 32'hFF);
    access("R3 one refuses", 32'h1850, 0, 1'b0, 1'b0);
    access("R3 all grant",   32'h1850, 0, 1'b1, 1'b1);
    access("R3 outside inner", 32'h1900, 0, 1'b0, 1'b1);
    idle();
  endtask

  task automatic test_next_cycle_and_domain();
    cfg(4, 0, 32'h4_0000); cfg(4, 1, 32'h4_FFFF); cfg(4, 2, 32'hFF);
    access("R11 not yet valid", 32'h4_0000, 3, 1'b1, 1'b0);
    cfg(4, 3, 32'h1);
    access("R11 next cycle", 32'h4_0000, 3, 1'b1, 1'b1);
    access("R5 did 4", 32'h4_0010, 4, 1'b0, 1'b0);
    access("R5 did 7", 32'h4_0010, 7, 1'b1, 1'b0);
    cfg(4, 3, 32'h0);
    access("R1 window removed", 32'h4_0010, 3, 1'b1, 1'b0);
    idle();
  endtask

  task automatic test_capture();
    @(negedge clk_i);
    cfg_we_i = 1'b0; acc_valid_i = 1'b0; cap_clr_i = 1'b1;
    @(posedge clk_i); #1;
    check("R10 clear", 32'(cap_valid_o), 0);
    access("R9 first err", 32'h9000, 2, 1'b1, 1'b0);
    check("R9 cap valid", 32'(cap_valid_o), 1);
    check("R9 cap addr",  cap_addr_o, 32'h9000);
    check("R9 cap did",   32'(cap_did_o), 2);
    check("R9 cap write", 32'(cap_write_o), 1);
    access("R9 second err", 32'hA000, 1, 1'b0, 1'b0);
    check("R9 cap kept addr", cap_addr_o, 32'h9000);
    check("R9 cap kept did",  32'(cap_did_o), 2);
    access("R10 clr with err", 32'hB000, 0, 1'b0, 1'b0, 1'b1);
    check("R10 cap valid", 32'(cap_valid_o), 1);
    check("R10 cap addr",  cap_addr_o, 32'hB000);
    check("R10 cap write", 32'(cap_write_o), 0);
    access("R8 allowed after err", 32'h1000, 0, 1'b0, 1'b1);
    idle();
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i); rst_ni = 1'b1;
    test_reset();
    test_single_bounds();
    test_direction();
    test_overlap();
    test_next_cycle_and_domain();
    test_capture();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    n_checks++; n_fails++;
    $display("FAIL watchdog: actual running expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule